// File: doc/BRIEF.md
# DMA Bridge Interrupt Aggregator

This block gathers the ten completion and error events of a DMA bridge that moves data for a USB buffer and for two audio channels, each with a playback and a record direction. Every event arrives as a one-cycle pulse. The pulse latches a sticky status bit, and that status bit is gated by a per-event enable bit. The gated results are combined into three level-sensitive interrupt lines for the CPU's interrupt controller.

Software sees one 32-bit control/status word through a simple select/write-enable port. A write loads all enables directly. For status bits a write only clears: writing 0 acknowledges the event, and writing 1 leaves the bit as it is. A read returns the whole word one cycle after the access. The grouping onto lines is uneven. The USB address error has a line to itself. USB transfer done shares a line with the four audio all-done events. The four audio half-done events share the third line.

Event ids: 0 is USB done and 1 is USB address error. Ids 2 to 9 go in pairs of all-done then half-done, in this order: audio 0 playback, audio 0 record, audio 1 playback, audio 1 record.

Top module: `brg_irq_agg`

## Requirements
- R1: After reset every status and enable bit is 0, all three interrupt lines are low and a read returns 32'h0000_0000.
- R2: A pulse on event id sets its status bit, whatever the enable bit holds. The status bit is at bit id for ids 0 and 1, and at bit id+14 for ids 2 to 9.
- R3: A write loads each enable bit from the write data. The enable bit is at bit id+8 for ids 0 and 1, and at bit id+22 for ids 2 to 9, which is always 8 above its status bit.
- R4: Writing 0 to a status bit clears it. Writing 1 to a status bit leaves it unchanged.
- R5: If an event pulse and a write of 0 to the same status bit fall in one cycle, the bit ends up set.
- R6: Line 0 (irq_line[0]) is high exactly while id 1 has both its status and its enable set.
- R7: Line 1 (irq_line[1]) is high while any of ids 0, 2, 4, 6 or 8 has both status and enable set.
- R8: Line 2 (irq_line[2]) is high while any of ids 3, 5, 7 or 9 has both status and enable set.
- R9: Bits 15:10 and 7:2 always read 0, and writing 1 to them has no effect.
- R10: A read access (bus_sel=1, bus_we=0) returns on bus_rdata, in the next cycle, the word as it stood before that clock edge. bus_rdata holds its value between reads.
- R11: An event whose enable is 0 still shows in its status bit on read, but it drives no interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 10 | One-cycle event pulses, bit n = event id n |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_line | output | 3 | Level interrupt lines 0..2 |

## Verification
The bench sets one of several enable patterns for each event and checks the read word and the three lines, so a wrong bit offset or a swapped line group shows up as a mismatched word or the wrong line. It writes all ones and expects the status bits and the reserved bits to be unchanged. A design that cleared on write-1 or stored reserved bits would fail this check. It drives an event pulse in the same cycle as a clearing write, where a design that gives the clear priority loses the event. It also reads in the same cycle as a pulse, where a design that forwards the new status would return the updated word too early.

// File: rtl/brg_irq_pkg.sv
`timescale 1ns/1ps
package brg_irq_pkg;
    localparam int NUM_EVT     = 10;
    localparam int NUM_LINE    = 3;
    localparam int REG_W       = 32;
    localparam int USB_EVT     = 2;
    localparam int AUD_STAT_LO = 16;
    localparam int ENB_OFS     = 8;

    typedef struct packed {
        logic stat;
        logic enb;
    } cell_t;

    // bit position of an event's status flag
    function automatic int stat_pos(input int id);
        return (id < USB_EVT) ? id : id + AUD_STAT_LO - USB_EVT;
    endfunction

    function automatic int enb_pos(input int id);
        return stat_pos(id) + ENB_OFS;
    endfunction

    // line routing: USB error alone, done events together, half events together
    function automatic int line_of(input int id);
        if (id == 1) return 0;
        if (id == 0) return 1;
        return (((id - USB_EVT) % 2) == 0) ? 1 : 2;
    endfunction

    function automatic logic [REG_W-1:0] used_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            m[stat_pos(i)] = 1'b1;
            m[enb_pos(i)]  = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/brg_evt_cell.sv
`timescale 1ns/1ps
module brg_evt_cell
    import brg_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic wr_en_i,
    input  logic wr_stat_i,
    input  logic wr_enb_i,
    output logic stat_o,
    output logic enb_o,
    output logic active_o
);
    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (wr_en_i) begin
            cell_d.enb = wr_enb_i;
            if (!wr_stat_i) cell_d.stat = 1'b0;
        end
        if (evt_i) cell_d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign stat_o   = cell_q.stat;
    assign enb_o    = cell_q.enb;
    assign active_o = cell_q.stat & cell_q.enb;

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> stat_o);
    // R4
    no_soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i && !stat_o) |=> !stat_o);
    // R3
    enb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (enb_o == $past(wr_enb_i)));
endmodule

// File: rtl/brg_irq_route.sv
`timescale 1ns/1ps
module brg_irq_route
    import brg_irq_pkg::*;
#(
    parameter int N_EVT  = NUM_EVT,
    parameter int N_LINE = NUM_LINE
) (
    input  logic [N_EVT-1:0]  active_i,
    output logic [N_LINE-1:0] line_o
);
    always_comb begin
        line_o = '0;
        for (int i = 0; i < N_EVT; i++) begin
            line_o[line_of(i)] = line_o[line_of(i)] | active_i[i];
        end
    end
endmodule

// File: rtl/brg_irq_regif.sv
`timescale 1ns/1ps
module brg_irq_regif
    import brg_irq_pkg::*;
#(
    parameter int N_EVT = NUM_EVT,
    parameter int DW    = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [N_EVT-1:0] stat_i,
    input  logic [N_EVT-1:0] enb_i,
    output logic             wr_en_o,
    output logic [N_EVT-1:0] wr_stat_o,
    output logic [N_EVT-1:0] wr_enb_o,
    output logic [DW-1:0]    bus_rdata
);
    localparam logic [DW-1:0] USED = used_mask();

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rif_t;

    rif_t          rif_d, rif_q;
    logic [DW-1:0] image;
    logic          rd_acc;

    assign rd_acc  = bus_sel & ~bus_we;
    assign wr_en_o = bus_sel & bus_we;

    always_comb begin
        image     = '0;
        wr_stat_o = '0;
        wr_enb_o  = '0;
        for (int i = 0; i < N_EVT; i++) begin
            image[stat_pos(i)] = stat_i[i];
            image[enb_pos(i)]  = enb_i[i];
            wr_stat_o[i]       = bus_wdata[stat_pos(i)];
            wr_enb_o[i]        = bus_wdata[enb_pos(i)];
        end
    end

    always_comb begin
        rif_d = rif_q;
        if (rd_acc) rif_d.rdata = image;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rif_q <= '0;
        else        rif_q <= rif_d;
    end

    assign bus_rdata = rif_q.rdata;

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~USED) == '0);
    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(bus_rdata));
endmodule

// File: rtl/brg_irq_agg.sv
`timescale 1ns/1ps
module brg_irq_agg
    import brg_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EVT-1:0]  evt_pulse,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    output logic [NUM_LINE-1:0] irq_line
);
    logic               wr_en;
    logic [NUM_EVT-1:0] wr_stat, wr_enb, stat, enb, active;

    brg_irq_regif #(.N_EVT(NUM_EVT), .DW(REG_W)) u_regif (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .stat_i(stat), .enb_i(enb),
        .wr_en_o(wr_en), .wr_stat_o(wr_stat), .wr_enb_o(wr_enb),
        .bus_rdata(bus_rdata)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_cell
        brg_evt_cell u_cell (
            .clk(clk), .rst_n(rst_n), .evt_i(evt_pulse[g]),
            .wr_en_i(wr_en), .wr_stat_i(wr_stat[g]), .wr_enb_i(wr_enb[g]),
            .stat_o(stat[g]), .enb_o(enb[g]), .active_o(active[g])
        );
    end

    brg_irq_route #(.N_EVT(NUM_EVT), .N_LINE(NUM_LINE)) u_route (
        .active_i(active), .line_o(irq_line)
    );

    // R11
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enb == '0) |-> (irq_line == '0));
endmodule

// File: tb/brg_irq_agg_tb.sv
`timescale 1ns/1ps
module brg_irq_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  evt_pulse = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_line;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    brg_irq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_line(irq_line)
    );

    // {enable word, event mask, expected read word, expected lines}
    localparam int NV = 12;
    localparam logic [76:0] VEC [NV] = '{
        {32'hFF000300, 10'h001, 32'hFF000301, 3'b010},
        {32'hFF000300, 10'h002, 32'hFF000302, 3'b001},
        {32'hFF000300, 10'h004, 32'hFF010300, 3'b010},
        {32'hFF000300, 10'h008, 32'hFF020300, 3'b100},
        {32'h00000000, 10'h3FF, 32'h00FF0003, 3'b000},
        {32'h01000000, 10'h3FF, 32'h01FF0003, 3'b010},
        {32'h02000000, 10'h200, 32'h02800000, 3'b000},
        {32'h80000000, 10'h200, 32'h80800000, 3'b100},
        {32'h00000200, 10'h001, 32'h00000201, 3'b000},
        {32'h00000100, 10'h001, 32'h00000101, 3'b010},
        {32'h40000000, 10'h100, 32'h40400000, 3'b010},
        {32'hFFFFFFFF, 10'h000, 32'hFF000300, 3'b000}
    };
    localparam string VTAG [NV] = '{
        "R2 R7", "R2 R6", "R2 R7", "R2 R8", "R11", "R3 R7",
        "R11", "R8", "R6 R11", "R3 R7", "R3 R7", "R4 R9"
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] d, input logic [9:0] ev);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = d; evt_pulse = ev;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; evt_pulse = '0;
    endtask

    task automatic bus_read(input logic [9:0] ev);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; evt_pulse = ev;
        @(negedge clk);
        bus_sel = 1'b0; evt_pulse = '0;
    endtask

    task automatic pulse(input logic [9:0] ev);
        @(negedge clk);
        evt_pulse = ev;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 lines", {29'd0, irq_line}, 32'd0);
        bus_read('0);
        chk("R1 read", bus_rdata, 32'h0);

        for (int v = 0; v < NV; v++) begin
            bus_write(32'h0, '0);
            bus_write(VEC[v][76:45], '0);
            pulse(VEC[v][44:35]);
            chk({VTAG[v], " lines"}, {29'd0, irq_line}, {29'd0, VEC[v][2:0]});
            bus_read('0);
            chk({VTAG[v], " read"}, bus_rdata, VEC[v][34:3]);
        end

        // R4 selective clear
        bus_write(32'h0, '0);
        bus_write(32'hFF000300, '0);
        pulse(10'h3FF);
        chk("R6 R7 R8 all lines", {29'd0, irq_line}, 32'd7);
        bus_write(32'hFFFE0303, '0);
        bus_read('0);
        chk("R4 clear one", bus_rdata, 32'hFFFE0303);
        bus_write(32'hFF000300, '0);
        chk("R4 cleared lines", {29'd0, irq_line}, 32'd0);
        bus_read('0);
        chk("R4 clear all", bus_rdata, 32'hFF000300);

        // R5 event beats clearing write
        bus_write(32'hFF000300, 10'h008);
        chk("R5 line", {29'd0, irq_line}, 32'd4);
        bus_read('0);
        chk("R5 read", bus_rdata, 32'hFF020300);

        // R10 read in same cycle as event returns old word
        bus_write(32'hFF000300, '0);
        bus_read(10'h001);
        chk("R10 old word", bus_rdata, 32'hFF000300);
        chk("R10 R7 line", {29'd0, irq_line}, 32'd2);
        repeat (3) @(negedge clk);
        chk("R10 hold", bus_rdata, 32'hFF000300);
        bus_read('0);
        chk("R10 new word", bus_rdata, 32'hFF000301);

        // R3 masking an already-set event drops its line, status stays
        bus_write(32'h00000001, '0);
        chk("R3 R11 masked line", {29'd0, irq_line}, 32'd0);
        bus_read('0);
        chk("R3 R11 masked read", bus_rdata, 32'h00000001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule